// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked system and an external 128K x 8 asynchronous static RAM. The RAM has two chip selects of opposite polarity, an active-low output enable and an active-low write enable. The host presents one word at a time: a request strobe, a write flag, a 17-bit address and 8 bits of write data. The controller answers with a one-cycle ready pulse, and for reads it also returns the data word. A busy flag tells the host when a new request will be taken.

Every analog timing limit is a parameter in nanoseconds. The controller divides each one by the clock period and rounds up to a whole number of cycles. The minimum limits (write pulse width, select-to-end-of-write, data-to-end-of-write, cycle time) set the length of the write pulse. The access maxima (address, select and output-enable access) together with the cycle time set the cycle in which read data is sampled. The data bus is split into an output word, a drive enable and an input word, so the pad tri-state stays outside this block.

When power returns from battery-backed retention, the chip must stay deselected for a long recovery period before any access. A power-good input restarts this hold-off whenever it is low. Busy stays high until the hold-off has run its full length.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: After reset, and while power-good is low, the chip is deselected (`mem_cs1_n`=1, `mem_cs2`=0, `mem_oe_n`=1, `mem_we_n`=1, `mem_dq_oe`=0) and `busy` is 1. `busy` falls after exactly RECOV_CYC consecutive clock edges at which power-good is sampled high.
- R2: Power-good sampled low at any edge aborts the access in progress, deselects the chip on the next cycle and restarts the full recovery count.
- R3: A request is taken only at an edge where `busy` is 0. A request presented while `busy` is 1 has no effect: nothing is written and the address bus does not change.
- R4: A write starts with one setup cycle in which the chips are selected, the address and data are driven and `mem_we_n`=1. Then comes the WE-low pulse. It ends with one hold cycle in which `mem_we_n`=1 and the chips stay selected. Address and data stay unchanged through all three phases.
- R5: The WE-low pulse lasts WE_CYC cycles, where WE_CYC is the largest of: ceil(T_WP/Tclk), ceil(T_CW/Tclk)-1, ceil(T_DW/Tclk)-1, ceil(T_RC/Tclk)-2 and 1.
- R6: A read holds the chips selected, `mem_oe_n`=0 and `mem_we_n`=1 for RD_CYC cycles. RD_CYC is the largest of ceil(T_RC), ceil(T_AA) and ceil(T_OE) in clock cycles. `mem_dq_in` is captured into `rd_data` at the edge that ends the last of these cycles.
- R7: `ready` is high for exactly one cycle: the cycle after a read's last cycle or after a write's hold cycle. `rd_data` is valid in that cycle.
- R8: `mem_dq_oe` is 1 only during the setup, pulse and hold cycles of a write, and never while `mem_oe_n` is 0.
- R9: A write taken in the `ready` cycle of a read is preceded by one turnaround cycle in which the chip is deselected and the bus is not driven.
- R10: `mem_we_n` is 0 only while the chip is selected and `mem_oe_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | High when the RAM supply is back at operating level |
| req | input | 1 | Access request, taken when busy is low |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write data |
| rd_data | output | 8 | Captured read data, valid with ready |
| ready | output | 1 | One-cycle completion pulse |
| busy | output | 1 | High during recovery or an access |
| mem_addr | output | 17 | RAM address bus |
| mem_cs1_n | output | 1 | Active-low chip select |
| mem_cs2 | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_oe | output | 1 | Drive enable for the data pads |
| mem_dq_out | output | 8 | Data toward the RAM |
| mem_dq_in | input | 8 | Data sampled from the RAM pads |

## Verification
The assertions assume that `rst_n` and `pwr_good` change only away from the clock edge, and that the host drives `req` together with a stable address and data for the cycle it is sampled. The bench drives every input on the falling clock edge, so each edge sees settled values. It never drops power-good during a write, which keeps the model RAM free of half-finished writes. The bench RAM returns a poison byte until the read has been active for the address access time, so a read sampled too early shows up as wrong data.

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl #(
  parameter int CLK_NS    = 10,
  parameter int T_RC_NS   = 55,
  parameter int T_AA_NS   = 55,
  parameter int T_OE_NS   = 25,
  parameter int T_WP_NS   = 40,
  parameter int T_CW_NS   = 45,
  parameter int T_DW_NS   = 25,
  parameter int RECOV_CYC = 500000,
  parameter int AW        = 17,
  parameter int DW        = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_good,
  input  logic          req,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic [DW-1:0] rd_data,
  output logic          ready,
  output logic          busy,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs1_n,
  output logic          mem_cs2,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic          mem_dq_oe,
  output logic [DW-1:0] mem_dq_out,
  input  logic [DW-1:0] mem_dq_in
);

  function automatic int cyc(input int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int WE_CYC = imax(imax(imax(cyc(T_WP_NS), cyc(T_CW_NS) - 1),
                                    imax(cyc(T_DW_NS) - 1, cyc(T_RC_NS) - 2)), 1);
  localparam int RD_CYC = imax(imax(cyc(T_AA_NS), cyc(T_OE_NS)), imax(cyc(T_RC_NS), 1));
  localparam int CNT_W  = $clog2(imax(RECOV_CYC, imax(WE_CYC, RD_CYC)) + 1);

  typedef enum logic [2:0] {
    S_RECOV, S_IDLE, S_TURN, S_WSET, S_WPUL, S_WHLD, S_READ
  } st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic             prev_rd;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q;

  wire writing = (st == S_WSET) || (st == S_WPUL) || (st == S_WHLD);
  wire sel     = writing || (st == S_READ);

  assign busy       = (st != S_IDLE);
  assign mem_cs1_n  = !sel;
  assign mem_cs2    = sel;
  assign mem_oe_n   = (st != S_READ);
  assign mem_we_n   = (st != S_WPUL);
  assign mem_dq_oe  = writing;
  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_RECOV;
      cnt     <= CNT_W'(RECOV_CYC);
      ready   <= 1'b0;
      prev_rd <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rd_data <= '0;
    end else if (!pwr_good) begin
      st      <= S_RECOV;
      cnt     <= CNT_W'(RECOV_CYC);
      ready   <= 1'b0;
      prev_rd <= 1'b0;
    end else begin
      ready   <= 1'b0;
      prev_rd <= 1'b0;
      case (st)
        S_RECOV: if (cnt <= 1) st <= S_IDLE; else cnt <= cnt - 1'b1;
        S_IDLE: if (req) begin
          addr_q <= req_addr;
          if (req_we) begin
            wdata_q <= req_wdata;
            st      <= prev_rd ? S_TURN : S_WSET;
          end else begin
            st  <= S_READ;
            cnt <= CNT_W'(RD_CYC);
          end
        end
        S_TURN: st <= S_WSET;
        S_WSET: begin
          st  <= S_WPUL;
          cnt <= CNT_W'(WE_CYC);
        end
        S_WPUL: if (cnt == 1) st <= S_WHLD; else cnt <= cnt - 1'b1;
        S_WHLD: begin
          st    <= S_IDLE;
          ready <= 1'b1;
        end
        S_READ: if (cnt == 1) begin
          rd_data <= mem_dq_in;
          ready   <= 1'b1;
          prev_rd <= 1'b1;
          st      <= S_IDLE;
        end else cnt <= cnt - 1'b1;
        default: st <= S_RECOV;
      endcase
    end
  end

  p_pwr_loss_deselects_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> (mem_cs1_n && !mem_cs2 && busy && mem_we_n));

  p_busy_req_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req && busy) |=> $stable(mem_addr));

  p_we_start_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> ($past(mem_dq_oe) && $stable(mem_addr) && $stable(mem_dq_out)));

  p_we_end_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_we_n) && mem_dq_oe) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

  p_ready_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);

  p_no_drive_on_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  p_turnaround_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> $past(mem_oe_n));

  p_we_in_select_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs1_n && mem_cs2 && mem_oe_n));

endmodule

// File: tb/sram_strobe_ctrl_bench.sv
module sram_strobe_ctrl_bench;
  localparam int CLK = 10, RC = 70, AA = 70, OEA = 35, WP = 50, CW = 60, DWT = 30;
  localparam int RECOV = 40;

  function automatic int c(input int ns); return (ns + CLK - 1) / CLK; endfunction
  function automatic int mx(input int a, input int b); return a > b ? a : b; endfunction
  localparam int WE_C = mx(mx(mx(c(WP), c(CW) - 1), mx(c(DWT) - 1, c(RC) - 2)), 1);
  localparam int RD_C = mx(mx(c(AA), c(OEA)), c(RC));
  localparam int AA_C = c(AA);

  logic clk = 0, rst_n = 0, pwr_good = 1, req = 0, req_we = 0;
  logic [16:0] req_addr = 0;
  logic [7:0]  req_wdata = 0, mem_dq_in = 8'hEE;
  logic [7:0]  rd_data, mem_dq_out;
  logic [16:0] mem_addr;
  logic ready, busy, mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n, mem_dq_oe;

  always #5 clk = ~clk;

  sram_strobe_ctrl #(.CLK_NS(CLK), .T_RC_NS(RC), .T_AA_NS(AA), .T_OE_NS(OEA),
    .T_WP_NS(WP), .T_CW_NS(CW), .T_DW_NS(DWT), .RECOV_CYC(RECOV)) u_sram_strobe_ctrl (
    .clk, .rst_n, .pwr_good, .req, .req_we, .req_addr, .req_wdata, .rd_data, .ready,
    .busy, .mem_addr, .mem_cs1_n, .mem_cs2, .mem_oe_n, .mem_we_n, .mem_dq_oe,
    .mem_dq_out, .mem_dq_in);

  int n_chk = 0, n_fail = 0, cycles = 0;
  bit finished = 0;

  function automatic logic [7:0] init_val(input logic [16:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // RAM model: data appears only after the address access time
  logic [7:0] ram [logic [16:0]];
  int rdcnt = 0;
  always @(negedge clk) begin
    if (!mem_cs1_n && mem_cs2 && !mem_oe_n && mem_we_n) rdcnt++; else rdcnt = 0;
    if (!mem_cs1_n && mem_cs2 && !mem_we_n) ram[mem_addr] = mem_dq_out;
    if (rdcnt >= AA_C) mem_dq_in = ram.exists(mem_addr) ? ram[mem_addr] : init_val(mem_addr);
    else mem_dq_in = 8'hEE;
  end

  // Behavioural reference model
  logic [7:0] shadow [logic [16:0]];
  int rec = RECOV, pos = -1, len = 0, wofs = 0;
  bit m_we = 0, m_rdy = 0, m_prev = 0, pr = 0;
  logic [16:0] m_addr = 0;
  logic [7:0]  m_data = 0, m_rd = 0;

  always @(posedge clk) begin
    if (!rst_n || !pwr_good) begin
      rec = RECOV; pos = -1; m_rdy = 0; m_prev = 0;
    end else if (rec > 0) begin
      rec--; m_rdy = 0; m_prev = 0;
    end else if (pos < 0) begin
      pr = m_prev; m_rdy = 0; m_prev = 0;
      if (req) begin
        m_addr = req_addr; m_we = req_we; pos = 0;
        if (req_we) begin
          m_data = req_wdata; shadow[req_addr] = req_wdata;
          wofs = pr ? 1 : 0; len = wofs + WE_C + 2;
        end else begin
          wofs = 0; len = RD_C;
        end
      end
    end else begin
      pos++; m_rdy = 0;
      if (pos == len) begin
        pos = -1; m_rdy = 1;
        if (!m_we) begin
          m_rd = shadow.exists(m_addr) ? shadow[m_addr] : init_val(m_addr);
          m_prev = 1;
        end
      end
    end
  end

  always @(negedge clk) if (rst_n && !finished) begin
    int k;
    bit act, ex_cs;
    act = (pos >= 0);
    k = pos - wofs;
    ex_cs = act && (!m_we || k >= 0);
    chk("R1", "busy", busy, (rec > 0) || act);
    chk("R7", "ready", ready, m_rdy);
    chk("R4", "cs1_n", mem_cs1_n, !ex_cs);
    chk("R4", "cs2", mem_cs2, ex_cs);
    chk("R6", "oe_n", mem_oe_n, !(act && !m_we));
    chk("R5", "we_n", mem_we_n, !(act && m_we && k >= 1 && k <= WE_C));
    chk("R8", "dq_oe", mem_dq_oe, act && m_we && k >= 0);
    if (ex_cs) chk("R4", "addr", mem_addr, m_addr);
    if (act && m_we && k >= 0) chk("R4", "dq_out", mem_dq_out, m_data);
    if (m_rdy && !m_we) chk("R6", "rd_data", rd_data, m_rd);
    if (!mem_we_n) chk("R10", "select during write", !mem_cs1_n && mem_cs2 && mem_oe_n, 1);
  end

  task automatic summary();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 30000 && !finished) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      summary();
    end
  end

  task automatic issue(input bit we, input logic [16:0] a, input logic [7:0] d);
    @(negedge clk);
    while (busy) @(negedge clk);
    req = 1; req_we = we; req_addr = a; req_wdata = d;
    @(negedge clk);
    req = 0;
  endtask

  task automatic wait_ready();
    while (!ready) @(negedge clk);
  endtask

  int n;
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1", "busy after reset", busy, 1);
    chk("R1", "deselected after reset", mem_cs1_n && !mem_cs2, 1);
    req = 1; req_we = 1; req_addr = 17'h00123; req_wdata = 8'hA5; // R3: ignored in recovery
    n = 0;
    do begin @(negedge clk); n++; end while (busy);
    req = 0;
    chk("R1", "recovery length", n, RECOV);

    issue(1, 17'h00000, 8'h11);
    issue(1, 17'h1FFFF, 8'h22);
    issue(1, 17'h0ABCD, 8'h33);
    issue(0, 17'h00000, 0); wait_ready(); chk("R6", "read low addr", rd_data, 8'h11);
    issue(0, 17'h1FFFF, 0); wait_ready(); chk("R6", "read high addr", rd_data, 8'h22);
    issue(0, 17'h00123, 0); wait_ready();
    chk("R3", "write during recovery dropped", rd_data, init_val(17'h00123));

    // R9: write issued in the ready cycle of a read
    issue(0, 17'h0ABCD, 0); wait_ready();
    chk("R7", "ready read data", rd_data, 8'h33);
    req = 1; req_we = 1; req_addr = 17'h0ABCD; req_wdata = 8'h5A;
    @(negedge clk); req = 0;
    chk("R9", "turnaround deselected", mem_cs1_n, 1);
    chk("R9", "turnaround bus idle", mem_dq_oe, 0);
    @(negedge clk);
    chk("R9", "setup after turnaround", mem_dq_oe, 1);
    // R4: back-to-back write in the ready cycle of a write, no turnaround
    wait_ready();
    req = 1; req_we = 1; req_addr = 17'h00FF0; req_wdata = 8'hC3;
    @(negedge clk); req = 0;
    chk("R4", "setup straight after write", mem_dq_oe && mem_we_n && !mem_cs1_n, 1);
    issue(0, 17'h0ABCD, 0); wait_ready(); chk("R6", "rewritten data", rd_data, 8'h5A);

    // R3: request while a read is running
    issue(0, 17'h00FF0, 0);
    req = 1; req_we = 1; req_addr = 17'h00F0F; req_wdata = 8'h77;
    @(negedge clk); @(negedge clk); req = 0;
    wait_ready(); chk("R6", "read during busy req", rd_data, 8'hC3);
    issue(0, 17'h00F0F, 0); wait_ready();
    chk("R3", "busy request not written", rd_data, init_val(17'h00F0F));

    // R2: power loss mid-read, then restart during recovery
    issue(0, 17'h1FFFF, 0);
    @(negedge clk); pwr_good = 0;
    @(negedge clk);
    chk("R2", "busy after power loss", busy, 1);
    chk("R2", "deselected after power loss", mem_cs1_n && !mem_cs2 && mem_oe_n, 1);
    repeat (4) @(negedge clk);
    pwr_good = 1;
    repeat (15) @(negedge clk);
    chk("R2", "still busy mid recovery", busy, 1);
    pwr_good = 0; @(negedge clk); pwr_good = 1;
    n = 0;
    do begin @(negedge clk); n++; end while (busy);
    chk("R2", "restarted recovery length", n, RECOV);
    issue(0, 17'h1FFFF, 0); wait_ready(); chk("R6", "data kept across retention", rd_data, 8'h22);

    repeat (3) @(negedge clk);
    summary();
  end
endmodule